// File: doc/BRIEF.md
# Segmented Effective Address Generator

This block turns an addressing-mode code and a set of register values into a 16-bit effective address (EA) and a 20-bit physical address (PA). The EA is built from up to three terms: a base register (BX or BP), an index register (SI or DI) and a displacement. The displacement is either a full 16-bit value or an 8-bit value that is sign-extended. The terms are summed modulo 2^16. The PA is the chosen segment value shifted left by four plus the EA, taken modulo 2^20.

A load-effective-address request returns only the EA. It issues no memory request and reports a PA of zero. The segment is the stack segment when BP serves as base or pointer, and the data segment otherwise. The address path is combinational. One output register stage with a valid flag gives the results a fixed one-cycle latency.

Top module: `eagen_unit`

## Requirements
- R1: Mode code 0 (direct) gives EA = the displacement (after R6 extension) and selects the data segment.
- R2: Mode code 1 (register indirect) gives EA = the register chosen by `ptr_sel` (0 BX, 1 BP, 2 SI, 3 DI) with no displacement. The stack segment is used only when `ptr_sel` is 1.
- R3: Mode code 2 (based) gives EA = base + displacement, with `base_sel` 0 choosing BX and 1 choosing BP. The stack segment is used exactly when BP is the base.
- R4: Mode code 3 (indexed) gives EA = index + displacement, with `idx_sel` 0 choosing SI and 1 choosing DI. It always uses the data segment.
- R5: Mode code 4 (based-indexed) gives EA = base + index + displacement. The segment rule is the same as in R3.
- R6: When `disp_short` is 1, only `disp[7:0]` is used, sign-extended from bit 7, so `disp[15:8]` has no effect. When `disp_short` is 0, all 16 bits are used.
- R7: The EA sum wraps modulo 65536.
- R8: For a memory request, PA = (segment × 16 + EA) mod 2^20. `out_stack` is 1 when the stack segment was used.
- R9: When `lea` is 1, `out_ea` holds the EA, while `out_pa`, `out_stack` and `out_mem` are 0. Otherwise `out_mem` follows `out_valid`.
- R10: Each cycle with `in_valid` high yields `out_valid` high on the following cycle with that request's results. A cycle with `in_valid` low yields `out_valid` low, and the data outputs keep their previous values.
- R11: While `rst_n` is low, all outputs are 0.
- R12: Mode codes 5, 6 and 7 behave exactly like direct mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present this cycle |
| mode | input | 3 | Addressing-mode code |
| base_sel | input | 1 | 0 BX, 1 BP |
| idx_sel | input | 1 | 0 SI, 1 DI |
| ptr_sel | input | 2 | Indirect pointer: 0 BX, 1 BP, 2 SI, 3 DI |
| disp_short | input | 1 | Sign-extend the low 8 displacement bits |
| lea | input | 1 | Request the offset only |
| disp | input | 16 | Displacement or direct offset |
| reg_bx | input | 16 | BX value |
| reg_bp | input | 16 | BP value |
| reg_si | input | 16 | SI value |
| reg_di | input | 16 | DI value |
| seg_data | input | 16 | Data segment value |
| seg_stack | input | 16 | Stack segment value |
| out_valid | output | 1 | Result valid |
| out_mem | output | 1 | Result is a memory request |
| out_stack | output | 1 | Stack segment was used |
| out_ea | output | 16 | Effective address |
| out_pa | output | 20 | Physical address |

## Verification
A wrong operand choice, extension or segment decision has no hidden state to sit in. It appears at `out_ea`, `out_pa` or `out_stack` on the cycle right after the request that exercises it. Wrap errors show only when the operands carry out of bit 15 or bit 19, so the directed cases force both carries. The random requests spread the mode, selector and short-displacement combinations. A fault in the output register shows as a missing or extra `out_valid`, or as data that changes during an idle cycle.

// File: rtl/eagen_pkg.sv
package eagen_pkg;
   typedef enum logic [2:0] {
      AM_DIRECT    = 3'd0,
      AM_INDIRECT  = 3'd1,
      AM_BASED     = 3'd2,
      AM_INDEXED   = 3'd3,
      AM_BASED_IDX = 3'd4
   } am_e;

   typedef enum logic [1:0] {
      PTR_BX = 2'd0,
      PTR_BP = 2'd1,
      PTR_SI = 2'd2,
      PTR_DI = 2'd3
   } ptr_e;
endpackage

// File: rtl/eagen_disp_ext.sv
module eagen_disp_ext #(
   parameter int AW      = 16,
   parameter int SHORT_W = 8
) (
   input  logic [AW-1:0] raw,
   input  logic          short_en,
   output logic [AW-1:0] val
);
   localparam int PAD = AW - SHORT_W;

   generate
      if (SHORT_W < 1 || SHORT_W >= AW) begin : g_bad
         $error("eagen_disp_ext: SHORT_W must be in 1..AW-1");
      end
   endgenerate

   logic [AW-1:0] ext;
   assign ext = {{PAD{raw[SHORT_W-1]}}, raw[SHORT_W-1:0]};
   assign val = short_en ? ext : raw;

   // R6: upper bits of a short displacement are copies of its sign bit
   always_comb begin
      if (short_en === 1'b1)
         p_short_sign_r6: assert (val[AW-1] == val[SHORT_W-1]);
   end
endmodule

// File: rtl/eagen_operand_sel.sv
module eagen_operand_sel
   import eagen_pkg::*;
#(
   parameter int AW = 16
) (
   input  logic [2:0]    mode,
   input  logic          base_sel,
   input  logic          idx_sel,
   input  logic [1:0]    ptr_sel,
   input  logic [AW-1:0] bx,
   input  logic [AW-1:0] bp,
   input  logic [AW-1:0] si,
   input  logic [AW-1:0] di,
   input  logic [AW-1:0] disp,
   output logic [AW-1:0] term_a,
   output logic [AW-1:0] term_b,
   output logic [AW-1:0] term_c,
   output logic          use_stack
);
   logic [AW-1:0] base_v, idx_v, ptr_v;

   assign base_v = base_sel ? bp : bx;
   assign idx_v  = idx_sel  ? di : si;

   always_comb begin
      unique case (ptr_e'(ptr_sel))
         PTR_BX:  ptr_v = bx;
         PTR_BP:  ptr_v = bp;
         PTR_SI:  ptr_v = si;
         default: ptr_v = di;
      endcase
   end

   always_comb begin
      term_a    = '0;
      term_b    = '0;
      term_c    = '0;
      use_stack = 1'b0;
      case (mode)
         AM_INDIRECT: begin
            term_a    = ptr_v;
            use_stack = (ptr_sel == PTR_BP);
         end
         AM_BASED: begin
            term_a    = base_v;
            term_c    = disp;
            use_stack = base_sel;
         end
         AM_INDEXED: begin
            term_b = idx_v;
            term_c = disp;
         end
         AM_BASED_IDX: begin
            term_a    = base_v;
            term_b    = idx_v;
            term_c    = disp;
            use_stack = base_sel;
         end
         default: term_c = disp;
      endcase
   end

   // R1, R4, R12: modes without BP never pick the stack segment
   always_comb begin
      if (mode == AM_DIRECT || mode == AM_INDEXED || mode > AM_BASED_IDX)
         p_data_seg_r1: assert (use_stack !== 1'b1);
      if (mode == AM_INDIRECT)
         p_indirect_nodisp_r2: assert (term_c == '0 && term_b == '0);
   end
endmodule

// File: rtl/eagen_sum.sv
module eagen_sum #(
   parameter int AW        = 16,
   parameter int ADD_STYLE = 0
) (
   input  logic [AW-1:0] a,
   input  logic [AW-1:0] b,
   input  logic [AW-1:0] c,
   output logic [AW-1:0] sum
);
   generate
      if (ADD_STYLE != 0 && ADD_STYLE != 1) begin : g_bad
         $error("eagen_sum: ADD_STYLE must be 0 or 1");
      end
      if (ADD_STYLE == 0) begin : g_direct
         assign sum = a + b + c;
      end else begin : g_csa
         logic [AW-1:0] s_v, c_v;
         assign s_v = a ^ b ^ c;
         assign c_v = (a & b) | (a & c) | (b & c);
         assign sum = s_v + {c_v[AW-2:0], 1'b0};
      end
   endgenerate
endmodule

// File: rtl/eagen_phys.sv
module eagen_phys #(
   parameter int AW         = 16,
   parameter int SHIFT      = 4,
   parameter int PHYS_SPLIT = 1,
   localparam int PAW       = AW + SHIFT
) (
   input  logic [AW-1:0]  seg,
   input  logic [AW-1:0]  ea,
   output logic [PAW-1:0] pa
);
   generate
      if (SHIFT < 1) begin : g_bad
         $error("eagen_phys: SHIFT must be at least 1");
      end
      if (PHYS_SPLIT != 0) begin : g_split
         logic [AW-1:0] hi;
         assign hi = seg + {{SHIFT{1'b0}}, ea[AW-1:SHIFT]};
         assign pa = {hi, ea[SHIFT-1:0]};
      end else begin : g_full
         assign pa = {seg, {SHIFT{1'b0}}} + {{SHIFT{1'b0}}, ea};
      end
   endgenerate
endmodule

// File: rtl/eagen_unit.sv
module eagen_unit #(
   parameter int AW         = 16,
   parameter int SEG_SHIFT  = 4,
   parameter int SHORT_W    = 8,
   parameter int ADD_STYLE  = 0,
   parameter int PHYS_SPLIT = 1,
   localparam int PAW       = AW + SEG_SHIFT
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           in_valid,
   input  logic [2:0]     mode,
   input  logic           base_sel,
   input  logic           idx_sel,
   input  logic [1:0]     ptr_sel,
   input  logic           disp_short,
   input  logic           lea,
   input  logic [AW-1:0]  disp,
   input  logic [AW-1:0]  reg_bx,
   input  logic [AW-1:0]  reg_bp,
   input  logic [AW-1:0]  reg_si,
   input  logic [AW-1:0]  reg_di,
   input  logic [AW-1:0]  seg_data,
   input  logic [AW-1:0]  seg_stack,
   output logic           out_valid,
   output logic           out_mem,
   output logic           out_stack,
   output logic [AW-1:0]  out_ea,
   output logic [PAW-1:0] out_pa
);
   generate
      if (AW < 8) begin : g_bad_aw
         $error("eagen_unit: AW must be at least 8");
      end
   endgenerate

   logic [AW-1:0]  disp_v, t_a, t_b, t_c, ea_c, seg_v;
   logic [PAW-1:0] pa_c;
   logic           stack_c;

   eagen_disp_ext #(.AW(AW), .SHORT_W(SHORT_W)) u_ext (
      .raw(disp), .short_en(disp_short), .val(disp_v)
   );

   eagen_operand_sel #(.AW(AW)) u_sel (
      .mode(mode), .base_sel(base_sel), .idx_sel(idx_sel), .ptr_sel(ptr_sel),
      .bx(reg_bx), .bp(reg_bp), .si(reg_si), .di(reg_di), .disp(disp_v),
      .term_a(t_a), .term_b(t_b), .term_c(t_c), .use_stack(stack_c)
   );

   eagen_sum #(.AW(AW), .ADD_STYLE(ADD_STYLE)) u_sum (
      .a(t_a), .b(t_b), .c(t_c), .sum(ea_c)
   );

   assign seg_v = stack_c ? seg_stack : seg_data;

   eagen_phys #(.AW(AW), .SHIFT(SEG_SHIFT), .PHYS_SPLIT(PHYS_SPLIT)) u_phys (
      .seg(seg_v), .ea(ea_c), .pa(pa_c)
   );

   logic valid_q, mem_q, stack_q;
   logic [AW-1:0]  ea_q;
   logic [PAW-1:0] pa_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         mem_q   <= 1'b0;
         stack_q <= 1'b0;
         ea_q    <= '0;
         pa_q    <= '0;
      end else begin
         valid_q <= in_valid;
         if (in_valid) begin
            ea_q    <= ea_c;
            mem_q   <= ~lea;
            stack_q <= lea ? 1'b0 : stack_c;
            pa_q    <= lea ? '0 : pa_c;
         end
      end
   end

   assign out_valid = valid_q;
   assign out_mem   = valid_q & mem_q;
   assign out_stack = stack_q;
   assign out_ea    = ea_q;
   assign out_pa    = pa_q;

   p_valid_pipe_r10: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   p_valid_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(out_ea) && $stable(out_pa) && $stable(out_stack)));
   p_lea_nomem_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_mem) |-> (out_pa == '0 && !out_stack));
   p_mem_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
      out_mem |-> out_valid);
   p_low_bits_r8: assert property (@(posedge clk) disable iff (!rst_n)
      out_mem |-> (out_pa[SEG_SHIFT-1:0] == out_ea[SEG_SHIFT-1:0]));
endmodule

// File: tb/eagen_unit_tb.sv
module eagen_unit_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [2:0]  mode = '0;
   logic        base_sel = 1'b0, idx_sel = 1'b0, disp_short = 1'b0, lea = 1'b0;
   logic [1:0]  ptr_sel = '0;
   logic [15:0] disp = '0, reg_bx = '0, reg_bp = '0, reg_si = '0, reg_di = '0;
   logic [15:0] seg_data = '0, seg_stack = '0;
   logic        out_valid, out_mem, out_stack;
   logic [15:0] out_ea;
   logic [19:0] out_pa;

   int total = 0;
   int bad = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   eagen_unit u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode),
      .base_sel(base_sel), .idx_sel(idx_sel), .ptr_sel(ptr_sel),
      .disp_short(disp_short), .lea(lea), .disp(disp),
      .reg_bx(reg_bx), .reg_bp(reg_bp), .reg_si(reg_si), .reg_di(reg_di),
      .seg_data(seg_data), .seg_stack(seg_stack),
      .out_valid(out_valid), .out_mem(out_mem), .out_stack(out_stack),
      .out_ea(out_ea), .out_pa(out_pa)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // returns {stack, pa[19:0], ea[15:0]}
   function automatic logic [36:0] model();
      logic [15:0] d, b, x, p, ea;
      logic [19:0] pa;
      logic st;
      d = disp_short ? {{8{disp[7]}}, disp[7:0]} : disp;
      b = base_sel ? reg_bp : reg_bx;
      x = idx_sel ? reg_di : reg_si;
      case (ptr_sel)
         2'd0: p = reg_bx;
         2'd1: p = reg_bp;
         2'd2: p = reg_si;
         default: p = reg_di;
      endcase
      st = 1'b0;
      case (mode)
         3'd1: begin ea = p; st = (ptr_sel == 2'd1); end
         3'd2: begin ea = b + d; st = base_sel; end
         3'd3: ea = x + d;
         3'd4: begin ea = b + x + d; st = base_sel; end
         default: ea = d;
      endcase
      pa = {(st ? seg_stack : seg_data), 4'h0} + {4'h0, ea};
      if (lea) begin pa = '0; st = 1'b0; end
      return {st, pa, ea};
   endfunction

   task automatic issue(input string req);
      logic [36:0] e;
      e = model();
      in_valid = 1'b1;
      @(posedge clk);
      #2;
      chk({req, " valid"}, 32'(out_valid), 32'd1);
      chk({req, " ea"}, 32'(out_ea), 32'(e[15:0]));
      chk({req, " pa"}, 32'(out_pa), 32'(e[35:16]));
      chk({req, " stack"}, 32'(out_stack), 32'(e[36]));
      chk({req, " mem R9"}, 32'(out_mem), 32'(!lea));
      @(negedge clk);
   endtask

   task automatic setup(input logic [2:0] m, input logic bs, input logic is,
                        input logic [1:0] ps, input logic [15:0] d,
                        input logic sh, input logic l);
      mode = m; base_sel = bs; idx_sel = is; ptr_sel = ps;
      disp = d; disp_short = sh; lea = l;
   endtask

   initial begin
      #2_000_000;
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [15:0] ea_hold;
      logic [19:0] pa_hold;
      void'($urandom(32'd1234));
      reg_bx = 16'h1000; reg_bp = 16'h2000; reg_si = 16'h0030; reg_di = 16'h0400;
      seg_data = 16'h1234; seg_stack = 16'h8000;
      repeat (2) @(negedge clk);
      // R11 reset state
      chk("R11 valid", 32'(out_valid), 0);
      chk("R11 ea", 32'(out_ea), 0);
      chk("R11 pa", 32'(out_pa), 0);
      chk("R11 mem", 32'(out_mem), 0);
      rst_n = 1'b1;
      @(negedge clk);

      setup(3'd0, 1, 1, 2'd1, 16'hABCD, 0, 0); issue("R1 direct");
      for (int k = 0; k < 4; k++) begin
         setup(3'd1, 0, 0, 2'(k), 16'h5555, 0, 0); issue("R2 indirect");
      end
      setup(3'd2, 0, 0, 2'd0, 16'h0010, 0, 0); issue("R3 based bx");
      setup(3'd2, 1, 0, 2'd0, 16'h0010, 0, 0); issue("R3 based bp");
      setup(3'd3, 1, 0, 2'd0, 16'h0002, 0, 0); issue("R4 indexed si");
      setup(3'd3, 0, 1, 2'd1, 16'h0002, 0, 0); issue("R4 indexed di");
      setup(3'd4, 1, 1, 2'd0, 16'h0004, 0, 0); issue("R5 based-indexed");
      setup(3'd2, 0, 0, 2'd0, 16'h3380, 1, 0); issue("R6 short negative");
      chk("R6 ea value", 32'(out_ea), 32'h0F80);
      setup(3'd2, 0, 0, 2'd0, 16'hFF7F, 1, 0); issue("R6 short positive");
      chk("R6 ea value", 32'(out_ea), 32'h107F);
      reg_bx = 16'hFFFF; reg_si = 16'h0002;
      setup(3'd4, 0, 0, 2'd0, 16'h0001, 0, 0); issue("R7 wrap");
      chk("R7 ea value", 32'(out_ea), 32'h0002);
      seg_data = 16'hFFFF; reg_si = 16'h0010;
      setup(3'd3, 0, 0, 2'd0, 16'h0000, 0, 0); issue("R8 pa wrap");
      chk("R8 pa value", 32'(out_pa), 32'h00000);
      setup(3'd4, 1, 0, 2'd0, 16'h0100, 0, 1); issue("R9 lea");
      for (int m = 5; m < 8; m++) begin
         setup(3'(m), 1, 1, 2'd1, 16'h4321, 0, 0); issue("R12 reserved");
      end
      // R10: idle cycle drops valid and holds data
      ea_hold = out_ea; pa_hold = out_pa;
      in_valid = 1'b0; reg_bx = 16'h7777; disp = 16'h9999;
      @(posedge clk); #2;
      chk("R10 valid drop", 32'(out_valid), 0);
      chk("R10 ea hold", 32'(out_ea), 32'(ea_hold));
      chk("R10 pa hold", 32'(out_pa), 32'(pa_hold));
      @(negedge clk);

      for (int n = 0; n < 400; n++) begin
         reg_bx = 16'($urandom); reg_bp = 16'($urandom);
         reg_si = 16'($urandom); reg_di = 16'($urandom);
         seg_data = 16'($urandom); seg_stack = 16'($urandom);
         setup(3'($urandom), 1'($urandom), 1'($urandom), 2'($urandom),
               16'($urandom), 1'($urandom), ($urandom % 5) == 0);
         issue("R5 R8 random");
         if (n % 7 == 0) begin
            in_valid = 1'b0;
            @(posedge clk); #2;
            chk("R10 gap", 32'(out_valid), 0);
            @(negedge clk);
         end
      end

      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule